// File: doc/BRIEF.md
# Sparse Select Guard

The guard sits between a datapath controller and the multiplexers and register enables it steers. Every multiplexer select travels as a sparse codeword of `SEL_W` bits drawn from a small legal table. Every register enable travels as a two-codeword pair, one codeword meaning asserted and one meaning deasserted. The guard hands each select on unchanged. It turns each enable into a single-rail bit that is high only for the exact asserted codeword. It flags any channel whose value lies outside its legal set in the same cycle. These flags, together with encoding errors reported by neighbouring blocks (substitution and key schedule logic), are ORed into one error flag. That flag is registered and sticky, and it feeds the controller.

The error flag is registered on purpose. The controller gates its output-valid on this flag while it also drives the enables being checked, so a combinational path would close a loop. Codewords in the default select table are at least Hamming distance 3 apart, and so are the two enable codewords. A single or double upset therefore can never turn one legal value into another.

Top module: `sparse_sel_guard`

## Requirements
- R1: Each select output slice `sel_o[c]` equals the matching input slice `sel_i[c]` in the same cycle, whether the value is legal or not.
- R2: A select slice holding one of the legal codes 0x16, 0x2D, 0x19 or 0x23 (6 bits, table index 0 at the lowest bits) leaves its `sel_err_o[c]` low.
- R3: A select slice holding any other 6-bit value drives its `sel_err_o[c]` high in the same cycle.
- R4: An enable slice equal to 3'b011 drives `en_o[e]` high with `en_err_o[e]` low. An enable slice equal to 3'b100 drives `en_o[e]` low with `en_err_o[e]` low.
- R5: An enable slice holding any value other than 3'b011 or 3'b100 drives `en_o[e]` low and `en_err_o[e]` high in the same cycle. `en_o[e]` and `en_err_o[e]` are never high together.
- R6: If any select error, enable error or `ext_err_i` bit is high at a rising clock edge, `err_q_o` is high after that edge. If none is high and `err_q_o` was low, it stays low.
- R7: Once set, `err_q_o` stays high until reset, even after every input returns to a legal value.
- R8: Asserting `rst_ni` low clears `err_q_o` to 0 at once.
- R9: `err_q_o` does not change between clock edges when an error input appears. The error takes effect only at the next rising edge.
- R10: An illegal value on one channel raises only that channel's error output. All other channels' error outputs stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | NUM_SEL*SEL_W | Sparse select codewords, channel c at bits c*SEL_W |
| sel_o | output | NUM_SEL*SEL_W | Buffered select codewords |
| sel_err_o | output | NUM_SEL | Per-select illegal-code flag |
| en_i | input | NUM_EN*EN_W | Sparse enable codewords, channel e at bits e*EN_W |
| en_o | output | NUM_EN | Single-rail enable, high only on the exact asserted codeword |
| en_err_o | output | NUM_EN | Per-enable illegal-code flag |
| ext_err_i | input | NUM_EXT | Encoding errors reported by neighbouring blocks |
| err_q_o | output | 1 | Registered sticky error flag |

## Verification
All per-channel results (passed-through selects, single-rail enables, error flags) are combinational. The bench drives them on the falling edge and samples them 1 ns later in the same cycle. The sticky flag lags by one register. The bench therefore reads it once just before the next rising edge to show it has not moved yet, and again after that edge to see it set. After that, further cycles with legal inputs confirm that the flag holds until reset.

// File: rtl/sparse_sel_guard.sv
module sparse_sel_guard #(
  parameter int unsigned SEL_W = 6,
  parameter int unsigned SEL_CODES_N = 4,
  parameter logic [SEL_CODES_N*SEL_W-1:0] SEL_CODES = {6'h23, 6'h19, 6'h2D, 6'h16},
  parameter int unsigned NUM_SEL = 3,
  parameter int unsigned EN_W = 3,
  parameter logic [EN_W-1:0] EN_HIGH = 3'b011,
  parameter logic [EN_W-1:0] EN_LOW = 3'b100,
  parameter int unsigned NUM_EN = 2,
  parameter int unsigned NUM_EXT = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NUM_SEL*SEL_W-1:0] sel_i,
  output logic [NUM_SEL*SEL_W-1:0] sel_o,
  output logic [NUM_SEL-1:0]       sel_err_o,
  input  logic [NUM_EN*EN_W-1:0]   en_i,
  output logic [NUM_EN-1:0]        en_o,
  output logic [NUM_EN-1:0]        en_err_o,
  input  logic [NUM_EXT-1:0]       ext_err_i,
  output logic                     err_q_o
);

  logic err_any;
  logic err_q;

  for (genvar c = 0; c < NUM_SEL; c++) begin : g_sel
    logic [SEL_W-1:0] code;
    logic             hit;
    assign code = sel_i[c*SEL_W +: SEL_W];
    always_comb begin
      hit = 1'b0;
      for (int k = 0; k < SEL_CODES_N; k++) begin
        if (code == SEL_CODES[k*SEL_W +: SEL_W]) hit = 1'b1;
      end
    end
    assign sel_o[c*SEL_W +: SEL_W] = code;
    assign sel_err_o[c] = ~hit;
  end

  for (genvar e = 0; e < NUM_EN; e++) begin : g_en
    logic [EN_W-1:0] code;
    assign code = en_i[e*EN_W +: EN_W];
    assign en_o[e] = (code == EN_HIGH);
    assign en_err_o[e] = (code != EN_HIGH) && (code != EN_LOW);
  end

  assign err_any = (|sel_err_o) | (|en_err_o) | (|ext_err_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else if (err_any) err_q <= 1'b1;
  end

  assign err_q_o = err_q;

endmodule

module sparse_sel_guard_chk #(
  parameter int unsigned NUM_SEL = 3,
  parameter int unsigned NUM_EN = 2,
  parameter int unsigned NUM_EXT = 2
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_SEL-1:0] sel_err_o,
  input logic [NUM_EN-1:0]  en_o,
  input logic [NUM_EN-1:0]  en_err_o,
  input logic [NUM_EXT-1:0] ext_err_i,
  input logic               err_q_o
);

  logic any_err;
  assign any_err = (|sel_err_o) || (|en_err_o) || (|ext_err_i);

  p_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_err |=> err_q_o);

  p_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!any_err && !err_q_o) |=> !err_q_o);

  p_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q_o |=> err_q_o);

  p_en_excl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_o & en_err_o) == '0);

  p_stable_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_q_o) |-> $past(any_err));

endmodule

bind sparse_sel_guard sparse_sel_guard_chk #(
  .NUM_SEL(NUM_SEL), .NUM_EN(NUM_EN), .NUM_EXT(NUM_EXT)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sel_err_o(sel_err_o), .en_o(en_o),
  .en_err_o(en_err_o), .ext_err_i(ext_err_i), .err_q_o(err_q_o)
);

// File: tb/sparse_sel_guard_tb_top.sv
module sparse_sel_guard_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [17:0] sel_i;
  logic [17:0] sel_o;
  logic [2:0]  sel_err_o;
  logic [5:0]  en_i;
  logic [1:0]  en_o;
  logic [1:0]  en_err_o;
  logic [1:0]  ext_err_i;
  logic        err_q_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  sparse_sel_guard dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(sel_i), .sel_o(sel_o),
    .sel_err_o(sel_err_o), .en_i(en_i), .en_o(en_o), .en_err_o(en_err_o),
    .ext_err_i(ext_err_i), .err_q_o(err_q_o)
  );

  localparam logic [5:0] OK_SEL = 6'h16;
  localparam logic [2:0] OK_EN = 3'b100;
  localparam int NV = 10;
  // {sel code, en code, expected sel_err, expected en_o, expected en_err}
  localparam logic [11:0] VEC [NV] = '{
    {6'h16, 3'b011, 1'b0, 1'b1, 1'b0},
    {6'h2D, 3'b100, 1'b0, 1'b0, 1'b0},
    {6'h19, 3'b011, 1'b0, 1'b1, 1'b0},
    {6'h23, 3'b100, 1'b0, 1'b0, 1'b0},
    {6'h17, 3'b111, 1'b1, 1'b0, 1'b1},
    {6'h00, 3'b000, 1'b1, 1'b0, 1'b1},
    {6'h3F, 3'b001, 1'b1, 1'b0, 1'b1},
    {6'h2C, 3'b010, 1'b1, 1'b0, 1'b1},
    {6'h16, 3'b110, 1'b0, 1'b0, 1'b1},
    {6'h18, 3'b011, 1'b1, 1'b1, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic all_legal();
    sel_i = {OK_SEL, OK_SEL, OK_SEL};
    en_i = {OK_EN, OK_EN};
    ext_err_i = '0;
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    all_legal();
    #1;
    chk("R8 reset clears flag", 32'(err_q_o), 32'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  initial begin
    all_legal();
    do_reset();
    @(negedge clk_i);
    #1;
    chk("R8 flag low after reset", 32'(err_q_o), 32'd0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk_i);
      sel_i[5:0] = VEC[i][11:6];
      en_i[2:0] = VEC[i][5:3];
      #1;
      chk("R1 passthrough", 32'(sel_o), 32'(sel_i));
      chk(VEC[i][2] ? "R3 illegal select" : "R2 legal select", 32'(sel_err_o[0]), 32'(VEC[i][2]));
      chk("R4 enable decode", 32'(en_o[0]), 32'(VEC[i][1]));
      chk("R5 enable error", 32'(en_err_o[0]), 32'(VEC[i][0]));
    end

    // R9 and R6: error appears mid-cycle, flag moves only at next edge
    do_reset();
    @(negedge clk_i);
    sel_i[17:12] = 6'h2C;
    #1;
    chk("R10 only channel 2 flags", 32'(sel_err_o), 32'b100);
    chk("R10 enables unaffected", 32'(en_err_o), 32'b00);
    chk("R9 flag not yet set", 32'(err_q_o), 32'd0);
    @(posedge clk_i);
    #1;
    chk("R6 flag set after edge", 32'(err_q_o), 32'd1);
    @(negedge clk_i);
    all_legal();
    repeat (5) @(posedge clk_i);
    #1;
    chk("R7 flag holds", 32'(err_q_o), 32'd1);

    // R6 external error pulse; R10 enable channel isolation
    do_reset();
    @(negedge clk_i);
    en_i[5:3] = 3'b000;
    #1;
    chk("R10 only enable 1 flags", 32'(en_err_o), 32'b10);
    chk("R10 selects unaffected", 32'(sel_err_o), 32'b000);
    @(negedge clk_i);
    all_legal();
    #1;
    chk("R6 enable error captured", 32'(err_q_o), 32'd1);

    do_reset();
    @(negedge clk_i);
    ext_err_i = 2'b10;
    #1;
    chk("R9 external not yet captured", 32'(err_q_o), 32'd0);
    @(negedge clk_i);
    ext_err_i = 2'b00;
    #1;
    chk("R6 external error captured", 32'(err_q_o), 32'd1);
    repeat (3) @(negedge clk_i);
    chk("R7 flag holds after external", 32'(err_q_o), 32'd1);

    // R6 no spurious set while legal
    do_reset();
    repeat (6) @(negedge clk_i);
    chk("R6 stays low when legal", 32'(err_q_o), 32'd0);

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk_i);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule